// File: doc/BRIEF.md
# Masked Vector Pack/Unpack Engine

This block moves the elements of one vector register into another under the control of a per-element mask. In pack mode it collects the source elements whose mask bit is set and places them side by side from index 0 of the destination, keeping their relative order. It also reports how many elements it placed. In unpack mode it does the inverse: source elements are taken in order from index 0 and dropped into the destination slots whose mask bit is set. Every other slot keeps the value it had before.

A request is accepted with a one-cycle `start` pulse. Along with it come the mode, the active length `vl`, the mask, the source vector and the prior destination contents. The engine then scans one mask index per cycle, from 0 upward. It keeps a read pointer for the scan and a separate write pointer for the packed side. A one-cycle `done` pulse marks the point where `dstOut` and `packLen` are final. Both stay valid until the next accepted request.

Top module: `vec_pack_unit`

## Requirements
- R1: After reset, `busy`, `done`, `packLen` and every bit of `dstOut` are 0.
- R2: In pack mode (`mode`=0), the source elements at set mask positions appear at destination indices 0, 1, 2, … in increasing source order. Element i of any vector bus sits at bits [i*EW +: EW]. For example, mask bits 1, 4, 5 and 7 set give source elements 1, 4, 5 and 7 at destination indices 0 to 3.
- R3: At `done`, `packLen` equals the number of set bits in mask[vl-1:0] in both modes. Mask bits at index `vl` and above have no effect on any output.
- R4: In pack mode, destination indices at and above `packLen` hold the values given on `dstIn` at start.
- R5: In unpack mode (`mode`=1), the k-th set mask position (counting from index 0 and from k=0) receives source element k.
- R6: In unpack mode, destination positions whose mask bit is 0, or whose index is at or above `vl`, hold their `dstIn` value.
- R7: A pack with an all-zero mask reports `packLen`=0 and leaves `dstOut` equal to `dstIn`.
- R8: `done` is high for exactly one cycle, `vl`+1 clock cycles after the edge that accepts `start`. `busy` is high from that edge until the end of the `done` cycle.
- R9: `start` and all request inputs are ignored while `busy` is high. The result is that of the accepted request.
- R10: `vl`=0 finishes after one cycle with `packLen`=0 and `dstOut`=`dstIn`. A `vl` above VLEN is treated as VLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when not busy |
| mode | input | 1 | 0 = pack, 1 = unpack |
| vl | input | $clog2(VLEN+1) | Active element count |
| mask | input | VLEN | Per-element select bits |
| srcVec | input | VLEN*EW | Source vector, element i at [i*EW +: EW] |
| dstIn | input | VLEN*EW | Prior destination contents |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| packLen | output | $clog2(VLEN+1) | Count of selected elements |
| dstOut | output | VLEN*EW | Resulting destination vector |

## Verification
The bench builds the engine with VLEN=8 and EW=8. At that size every one of the 256 mask patterns can be swept at full length in both modes, against a model computed in the bench. This covers the empty mask, the full mask, isolated bits at both ends, and every pack/unpack pairing. Directed cases add the documented example, short and zero lengths with stray high mask bits, an over-range length, and requests fired at the engine while it is busy.

// File: rtl/vpack_pkg.sv
package vpack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } vpState_e;

  typedef enum logic {
    MODE_PACK   = 1'b0,
    MODE_UNPACK = 1'b1
  } vpMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture a new request
    logic step;  // process element at the read index
  } vpStrobe_t;
endpackage

// File: rtl/vpack_ctrl.sv
module vpack_ctrl
  import vpack_pkg::*;
#(
  parameter int VLEN = 8,
  localparam int IW = $clog2(VLEN),
  localparam int LW = $clog2(VLEN + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [LW-1:0] vl,
  output vpStrobe_t     strobe,
  output logic [IW-1:0] rdIdx,
  output logic          busy,
  output logic          done
);
  vpState_e state;
  logic [LW-1:0] vlReg;
  logic [LW-1:0] vlEff;
  logic          lastEl;
  logic          accept;

  assign vlEff  = (vl > LW'(VLEN)) ? LW'(VLEN) : vl;
  assign accept = start && (state == ST_IDLE);
  assign lastEl = ((LW'(rdIdx) + LW'(1)) == vlReg);

  always_comb begin
    strobe.load = accept;
    strobe.step = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rdIdx <= '0;
      vlReg <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          vlReg <= vlEff;
          rdIdx <= '0;
          state <= (vlEff == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          if (lastEl) state <= ST_FIN;
          else        rdIdx <= rdIdx + IW'(1);
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8: busy covers the done cycle
  a_r8_busy_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  // R9: an ongoing scan advances by one and is not restarted by start
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !lastEl) |=> (state == ST_RUN && rdIdx == $past(rdIdx) + IW'(1)));
endmodule

// File: rtl/vpack_datapath.sv
module vpack_datapath
  import vpack_pkg::*;
#(
  parameter int VLEN = 8,
  parameter int EW   = 8,
  localparam int IW = $clog2(VLEN),
  localparam int LW = $clog2(VLEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  vpStrobe_t          strobe,
  input  logic [IW-1:0]      rdIdx,
  input  logic               mode,
  input  logic [VLEN-1:0]    mask,
  input  logic [VLEN*EW-1:0] srcVec,
  input  logic [VLEN*EW-1:0] dstIn,
  output logic [LW-1:0]      packLen,
  output logic [VLEN*EW-1:0] dstOut
);
  logic [EW-1:0]   srcArr [VLEN];
  logic [EW-1:0]   dstArr [VLEN];
  logic [VLEN-1:0] maskReg;
  vpMode_e         modeReg;
  logic [LW-1:0]   wrPtr;
  logic [IW-1:0]   wrIdx;
  logic            selBit;

  assign wrIdx  = wrPtr[IW-1:0];
  assign selBit = maskReg[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      modeReg <= MODE_PACK;
      wrPtr   <= '0;
      for (int i = 0; i < VLEN; i++) begin
        srcArr[i] <= '0;
        dstArr[i] <= '0;
      end
    end else if (strobe.load) begin
      maskReg <= mask;
      modeReg <= vpMode_e'(mode);
      wrPtr   <= '0;
      for (int i = 0; i < VLEN; i++) begin
        srcArr[i] <= srcVec[i*EW +: EW];
        dstArr[i] <= dstIn[i*EW +: EW];
      end
    end else if (strobe.step && selBit) begin
      if (modeReg == MODE_PACK) dstArr[wrIdx] <= srcArr[rdIdx];
      else                      dstArr[rdIdx] <= srcArr[wrIdx];
      wrPtr <= wrPtr + LW'(1);
    end
  end

  assign packLen = wrPtr;

  for (genvar g = 0; g < VLEN; g++) begin : gOut
    assign dstOut[g*EW +: EW] = dstArr[g];
  end

  // R3: an unselected element never advances the write pointer
  a_r3_skip_unselected: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && !selBit) |=> $stable(wrPtr));
  // R2: write pointer never overtakes the read index
  a_r2_wr_behind_rd: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load) |=> (wrPtr <= LW'($past(rdIdx)) + LW'(1)));
  // R6: unpack keeps unselected destination slots
  a_r6_unpack_keep: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && modeReg == MODE_UNPACK && !selBit)
      |=> (dstArr[$past(rdIdx)] == $past(dstArr[rdIdx])));
endmodule

// File: rtl/vec_pack_unit.sv
module vec_pack_unit
  import vpack_pkg::*;
#(
  parameter int VLEN = 8,
  parameter int EW   = 8,
  localparam int IW = $clog2(VLEN),
  localparam int LW = $clog2(VLEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               mode,
  input  logic [LW-1:0]      vl,
  input  logic [VLEN-1:0]    mask,
  input  logic [VLEN*EW-1:0] srcVec,
  input  logic [VLEN*EW-1:0] dstIn,
  output logic               busy,
  output logic               done,
  output logic [LW-1:0]      packLen,
  output logic [VLEN*EW-1:0] dstOut
);
  vpStrobe_t     strobe;
  logic [IW-1:0] rdIdx;

  vpack_ctrl #(.VLEN(VLEN)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .vl(vl),
    .strobe(strobe), .rdIdx(rdIdx), .busy(busy), .done(done)
  );

  vpack_datapath #(.VLEN(VLEN), .EW(EW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdIdx(rdIdx),
    .mode(mode), .mask(mask), .srcVec(srcVec), .dstIn(dstIn),
    .packLen(packLen), .dstOut(dstOut)
  );

  // R1: outputs are clear in the cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (!busy && !done && packLen == '0 && dstOut == '0));
endmodule

// File: tb/sim_vec_pack_unit.sv
module sim_vec_pack_unit;
  localparam int VLEN = 8;
  localparam int EW   = 8;
  localparam int LW   = $clog2(VLEN + 1);
  localparam int VW   = VLEN * EW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          mode = 1'b0;
  logic [LW-1:0] vl = '0;
  logic [VLEN-1:0] mask = '0;
  logic [VW-1:0] srcVec = '0;
  logic [VW-1:0] dstIn = '0;
  logic          busy, done;
  logic [LW-1:0] packLen;
  logic [VW-1:0] dstOut;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  vec_pack_unit #(.VLEN(VLEN), .EW(EW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .vl(vl),
    .mask(mask), .srcVec(srcVec), .dstIn(dstIn),
    .busy(busy), .done(done), .packLen(packLen), .dstOut(dstOut)
  );

  task automatic check(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int effLen(input int v);
    return (v > VLEN) ? VLEN : v;
  endfunction

  function automatic int modelLen(input int v, input logic [VLEN-1:0] m);
    int n = 0;
    for (int i = 0; i < effLen(v); i++) if (m[i]) n++;
    return n;
  endfunction

  function automatic logic [VW-1:0] modelDst(input bit md, input int v, input logic [VLEN-1:0] m,
                                             input logic [VW-1:0] s, input logic [VW-1:0] d);
    logic [VW-1:0] r = d;
    int k = 0;
    for (int i = 0; i < effLen(v); i++) begin
      if (m[i]) begin
        if (!md) r[k*EW +: EW] = s[i*EW +: EW];
        else     r[i*EW +: EW] = s[k*EW +: EW];
        k++;
      end
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] fillVec(input logic [7:0] base);
    logic [VW-1:0] r;
    for (int i = 0; i < VLEN; i++) r[i*EW +: EW] = EW'(base + 8'(i));
    return r;
  endfunction

  // issue one request and check latency, pulse width, length and destination
  task automatic runOp(input bit md, input int v, input logic [VLEN-1:0] m,
                       input logic [VW-1:0] s, input logic [VW-1:0] d,
                       input string tag, input bit disturb);
    int cyc;
    logic [VW-1:0] expDst;
    int expLen;
    expDst = modelDst(md, v, m, s, d);
    expLen = modelLen(v, m);
    @(negedge clk);
    mode = md; vl = LW'(v); mask = m; srcVec = s; dstIn = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (disturb) begin
      mode = ~md; vl = LW'(VLEN); mask = ~m; srcVec = ~s; dstIn = ~d; start = 1'b1;
    end
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    check(done && cyc == effLen(v) + 1, {tag, " R8 done latency"}, VW'(cyc), VW'(effLen(v) + 1));
    check(packLen == LW'(expLen), {tag, " R3 packLen"}, VW'(packLen), VW'(expLen));
    check(dstOut == expDst, {tag, md ? " R5 R6 unpack dst" : " R2 R4 pack dst"}, dstOut, expDst);
    @(negedge clk);
    start = 1'b0;
    check(!done && !busy, {tag, " R8 done single pulse"}, VW'({done, busy}), '0);
  endtask

  task automatic tReset();
    check(!busy && !done && packLen == '0 && dstOut == '0, "R1 reset state",
          {dstOut[VW-1:LW+2], packLen, busy, done}, '0);
  endtask

  task automatic tExample();
    // R2: mask bits 7,5,4,1 -> elements 1,4,5,7 at indices 0..3
    logic [VW-1:0] s = fillVec(8'h10);
    logic [VW-1:0] d = fillVec(8'hA0);
    runOp(1'b0, 8, 8'b1011_0010, s, d, "example", 1'b0);
    check(dstOut[31:0] == {8'h17, 8'h15, 8'h14, 8'h11}, "R2 example order",
          VW'(dstOut[31:0]), VW'({8'h17, 8'h15, 8'h14, 8'h11}));
    check(dstOut[63:32] == d[63:32], "R4 upper slots kept", VW'(dstOut[63:32]), VW'(d[63:32]));
  endtask

  task automatic tEmptyMask();
    logic [VW-1:0] d = fillVec(8'h5C);
    runOp(1'b0, 8, 8'h00, fillVec(8'h01), d, "R7 empty", 1'b0);
    check(packLen == '0 && dstOut == d, "R7 empty mask no write", dstOut, d);
  endtask

  task automatic tExpand();
    logic [VW-1:0] s = fillVec(8'h30);
    logic [VW-1:0] d = fillVec(8'hC0);
    runOp(1'b1, 8, 8'b1011_0010, s, d, "unpack", 1'b0);
    // R5: slots 1,4,5,7 get elements 0,1,2,3; R6: others keep dstIn
    check(dstOut[15:8] == 8'h30 && dstOut[39:32] == 8'h31 && dstOut[47:40] == 8'h32 && dstOut[63:56] == 8'h33,
          "R5 unpack placement", dstOut, s);
    check(dstOut[7:0] == 8'hC0 && dstOut[31:16] == d[31:16] && dstOut[55:48] == 8'hC6,
          "R6 unpack keep", dstOut, d);
  endtask

  task automatic tShortVl();
    // R3: high mask bits beyond vl ignored in both modes
    runOp(1'b0, 3, 8'hFE, fillVec(8'h40), fillVec(8'h90), "R3 short pack", 1'b0);
    runOp(1'b1, 5, 8'hF5, fillVec(8'h40), fillVec(8'h90), "R3 short unpack", 1'b0);
  endtask

  task automatic tZeroAndOver();
    logic [VW-1:0] d = fillVec(8'hE0);
    runOp(1'b0, 0, 8'hFF, fillVec(8'h20), d, "R10 vl zero", 1'b0);
    check(dstOut == d && packLen == '0, "R10 vl zero untouched", dstOut, d);
    runOp(1'b1, 0, 8'hFF, fillVec(8'h20), d, "R10 vl zero unpack", 1'b0);
    runOp(1'b0, 9, 8'hA5, fillVec(8'h20), d, "R10 vl clamp", 1'b0);
  endtask

  task automatic tBusyStart();
    // R9: conflicting request held high during the whole run
    runOp(1'b0, 8, 8'h6C, fillVec(8'h70), fillVec(8'hB0), "R9 busy start", 1'b1);
    runOp(1'b1, 6, 8'h3B, fillVec(8'h70), fillVec(8'hB0), "R9 busy start unpack", 1'b1);
  endtask

  task automatic tSweep();
    for (int m = 0; m < 256; m++) begin
      runOp(1'b0, 8, 8'(m), fillVec(8'(m)), fillVec(8'(m ^ 8'h5A)), "sweep pack", 1'b0);
      runOp(1'b1, 8, 8'(m), fillVec(8'(m)), fillVec(8'(m ^ 8'h5A)), "sweep unpack", 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tExample();
    tEmptyMask();
    tExpand();
    tShortVl();
    tZeroAndOver();
    tBusyStart();
    tSweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule